// File: doc/BRIEF.md
# Johnson-Counter Stepped Sine Synthesizer

This block builds a symmetric staircase approximation of a sine wave from a seven-stage twisted-ring counter. Each cycle in which the step enable is high moves the counter one state along its 14-state loop. One period of the staircase is therefore 14 enabled steps. Changing how often the enable fires changes the output frequency, and the phase carries on from wherever it was, with no jump.

Six of the seven stage outputs are brought out as a tap vector. They are also multiplied by six integer weights and summed, which is the digital counterpart of a weighted resistor network. The weights are mirror-symmetric, so the staircase is symmetric and has no even harmonics. Well-chosen values also cancel the low odd harmonics.

A one-cycle strobe marks the start of each period. A downstream converter or filter uses the registered level, and the tap vector is there for a stage that does the weighting itself.

Top module: `jsine_synth`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the tap vector, the level output and the cycle strobe to zero on that edge, and no strobe is raised by reset.
- R2: Each edge with stepEn high advances the tap vector, written taps[5] down to taps[0], one position through the 14-entry loop 000000, 000000, 100000, 110000, 111000, 111100, 111110, 111111, 111111, 011111, 001111, 000111, 000011, 000001, then back to the first entry.
- R3: An edge with stepEn low leaves the tap vector and the level unchanged and raises no strobe.
- R4: On every edge after reset, the level output takes the sum of WEIGHTS[k] over the bits k set in the tap vector as it stood before that edge. The level therefore follows a tap change by exactly one cycle.
- R5: cycleStart is high for exactly the one cycle in which the tap vector enters the first all-zero loop entry from 000001, and it is low at all other times.
- R6: The period is counted in enabled steps only. Any spacing of stepEn pulses gives the same tap and level sequence with no skipped or repeated loop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Advance the ring by one state on this edge |
| taps | output | 6 | Six ring stage outputs used for weighting |
| level | output | SUM_W | Registered weighted sum of the taps |
| cycleStart | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench builds the block with small weights of 5, 11, 17, 17, 11, 5, a 5-bit weight width and an 8-bit sum. Every staircase level is then distinct enough that a swapped, dropped or shifted tap gives a wrong sum. Runs of continuous steps cross the period wrap more than once. Enable patterns with gaps and a reset in mid-period show that the phase is held, not lost, and that the strobe fires only on a real wrap.

// File: rtl/jsine_pkg.sv
package jsine_pkg;
  localparam int STAGES = 7;
  localparam int TAPS   = STAGES - 1;

  typedef struct packed {
    logic sumEn;       // ring moved on the previous edge
    logic cycleStart;  // ring just wrapped into the first zero state
  } ctrlStrobes_t;
endpackage

// File: rtl/jsine_ctrl.sv
module jsine_ctrl
  import jsine_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stepEn,
  output logic [TAPS-1:0]   taps,
  output ctrlStrobes_t      strobes
);
  localparam logic [STAGES-1:0] LAST_STATE = STAGES'(1) << (STAGES - 1);

  logic [STAGES-1:0] ringQ;
  logic [STAGES-1:0] ringNext;
  logic              legal;

  // A state is legal when it is a run of ones from bit 0 or its complement.
  function automatic logic isLegal(input logic [STAGES-1:0] v);
    logic ok;
    logic [STAGES-1:0] fill;
    ok = 1'b0;
    for (int n = 0; n <= STAGES; n++) begin
      fill = STAGES'((64'd1 << n) - 64'd1);
      if (v == fill || v == ~fill) ok = 1'b1;
    end
    return ok;
  endfunction

  assign legal = isLegal(ringQ);

  always_comb begin
    if (!legal)      ringNext = '0;
    else if (stepEn) ringNext = {ringQ[STAGES-2:0], ~ringQ[STAGES-1]};
    else             ringNext = ringQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ringQ              <= '0;
      strobes.sumEn      <= 1'b0;
      strobes.cycleStart <= 1'b0;
    end else begin
      ringQ              <= ringNext;
      strobes.sumEn      <= stepEn & legal;
      strobes.cycleStart <= stepEn & legal & (ringQ == LAST_STATE);
    end
  end

  // Stage 0 is left out; taps[TAPS-1] is the first stage to fill.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign taps[TAPS-1-k] = ringQ[k+1];
  end
endmodule

// File: rtl/jsine_dp.sv
module jsine_dp
  import jsine_pkg::*;
#(
  parameter int          WGT_W = 8,
  parameter int          SUM_W = WGT_W + 3,
  parameter int unsigned WEIGHTS [TAPS] = '{28, 50, 62, 62, 50, 28}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAPS-1:0]  taps,
  input  ctrlStrobes_t     strobes,
  output logic [SUM_W-1:0] level
);
  logic [SUM_W-1:0] terms [TAPS];
  logic [SUM_W-1:0] sumNext;

  for (genvar k = 0; k < TAPS; k++) begin : g_term
    localparam logic [WGT_W-1:0] W_K = WGT_W'(WEIGHTS[k]);
    assign terms[k] = taps[k] ? SUM_W'(W_K) : '0;
  end

  always_comb begin
    sumNext = '0;
    for (int k = 0; k < TAPS; k++) sumNext = sumNext + terms[k];
  end

  always_ff @(posedge clk) begin
    if (rst)                level <= '0;
    else if (strobes.sumEn) level <= sumNext;
  end
endmodule

// File: rtl/jsine_synth.sv
module jsine_synth
  import jsine_pkg::*;
#(
  parameter int          WGT_W = 8,
  parameter int          SUM_W = WGT_W + 3,
  parameter int unsigned WEIGHTS [TAPS] = '{28, 50, 62, 62, 50, 28}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  output logic [TAPS-1:0]  taps,
  output logic [SUM_W-1:0] level,
  output logic             cycleStart
);
  ctrlStrobes_t strobes;

  jsine_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stepEn (stepEn),
    .taps   (taps),
    .strobes(strobes)
  );

  jsine_dp #(.WGT_W(WGT_W), .SUM_W(SUM_W), .WEIGHTS(WEIGHTS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .taps   (taps),
    .strobes(strobes),
    .level  (level)
  );

  assign cycleStart = strobes.cycleStart;
endmodule

// File: rtl/jsine_chk.sv
module jsine_chk
  import jsine_pkg::*;
#(
  parameter int          WGT_W = 8,
  parameter int          SUM_W = WGT_W + 3,
  parameter int unsigned WEIGHTS [TAPS] = '{28, 50, 62, 62, 50, 28}
) (
  input logic             clk,
  input logic             rst,
  input logic             stepEn,
  input logic [TAPS-1:0]  taps,
  input logic [SUM_W-1:0] level,
  input logic             cycleStart
);
  function automatic logic [SUM_W-1:0] weigh(input logic [TAPS-1:0] t);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      if (t[k]) acc = acc + SUM_W'(WEIGHTS[k]);
    return acc;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (taps == '0 && level == '0 && !cycleStart));

  p_one_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
    stepEn |=> $countones(taps ^ $past(taps)) <= 1);

  p_hold_taps_r3: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> ($stable(taps) && !cycleStart));

  p_level_sum_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> level == weigh($past(taps)));

  p_strobe_zero_r5: assert property (@(posedge clk) disable iff (rst)
    cycleStart |-> taps == '0);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    cycleStart |=> !cycleStart);
endmodule

bind jsine_synth jsine_chk #(.WGT_W(WGT_W), .SUM_W(SUM_W), .WEIGHTS(WEIGHTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stepEn    (stepEn),
  .taps      (taps),
  .level     (level),
  .cycleStart(cycleStart)
);

// File: tb/test_jsine_synth.sv
module test_jsine_synth;
  localparam int          WGT_W = 5;
  localparam int          SUM_W = 8;
  localparam int unsigned WTS [6] = '{5, 11, 17, 17, 11, 5};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stepEn = 1'b0;
  logic [5:0]       taps;
  logic [SUM_W-1:0] level;
  logic             cycleStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jsine_synth #(.WGT_W(WGT_W), .SUM_W(SUM_W), .WEIGHTS(WTS)) i_jsine_synth (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .taps(taps), .level(level), .cycleStart(cycleStart)
  );

  typedef struct {
    logic [5:0]       t;
    logic [SUM_W-1:0] l;
    logic             s;
    string            tag;
  } item_t;

  item_t sbq [$];

  int               phase = 0;
  logic [SUM_W-1:0] lvlModel = '0;

  function automatic logic [5:0] expTaps(input int p);
    int n;
    if (p <= 7) begin
      n = (p == 0) ? 0 : p - 1;
      return 6'((7'h3F << (6 - n)) & 7'h3F);
    end
    n = 14 - p;
    return 6'((7'd1 << n) - 7'd1);
  endfunction

  function automatic logic [SUM_W-1:0] expLevel(input logic [5:0] t);
    int acc = 0;
    for (int k = 0; k < 6; k++) if (t[k]) acc += WTS[k];
    return SUM_W'(acc);
  endfunction

  // Driver: set inputs before the edge, push what the edge should produce.
  task automatic drive(input bit en, input bit r, input string tag);
    item_t it;
    @(negedge clk);
    stepEn = en;
    rst    = r;
    if (r) begin
      phase = 0; lvlModel = '0; it.s = 1'b0;
    end else begin
      lvlModel = expLevel(expTaps(phase));
      it.s     = en && (phase == 13);
      if (en) phase = (phase + 1) % 14;
    end
    it.t = expTaps(phase);
    it.l = lvlModel;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: sample shortly after each edge and compare with the queue.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t e;
        e = sbq.pop_front();
        check(taps == e.t, e.tag, int'(taps), int'(e.t));
        check(level == e.l, (e.tag == "R1") ? "R1" : "R4", int'(level), int'(e.l));
        check(cycleStart == e.s, (e.tag == "R1") ? "R1" : "R5", int'(cycleStart), int'(e.s));
      end
    end
  end

  initial begin
    repeat (3) drive(1'b0, 1'b1, "R1");
    // R2 continuous stepping across two wraps
    repeat (30) drive(1'b1, 1'b0, "R2");
    // R3 idle edges hold state
    repeat (5) drive(1'b0, 1'b0, "R3");
    // R6 irregular enable spacing
    for (int i = 0; i < 60; i++) drive(((i % 3) == 0) || ((i % 7) == 2), 1'b0, "R6");
    // R1 reset in mid-period, then resume
    repeat (5) drive(1'b1, 1'b0, "R2");
    repeat (2) drive(1'b1, 1'b1, "R1");
    repeat (16) drive(1'b1, 1'b0, "R2");
    drive(1'b0, 1'b0, "R3");
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R2", sbq.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule